// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects a bank of peripheral interrupt request lines and presents one active-low interrupt line to a processor core. Each channel has an enable bit, a pending bit and a source register. The source register holds a 16-bit vector fragment and a priority level. When a pending, enabled channel outranks the level now being served, the controller pulls its output low. It also loads the low half of a vector register with that channel's fragment. The upper half of the vector register is a common base that software writes, so one read of the vector register gives the handler address or instruction.

Reading the vector register is the acknowledge. On that read the controller pushes the current level and channel onto a hardware context stack. It then makes the accepted channel the current one and releases its output. A higher-level request can therefore interrupt a handler that is running. Software ends a handler by writing a 1 to the served channel's bit in the pending register. That write clears the bit, pops the saved level and channel, and rebuilds the vector of the interrupted handler.

Register access uses a simple single-cycle bus with 32-bit word addresses. Read data is combinational, and writes take effect at the clock edge.

Top module: `vnic`

## Requirements
- R1: After reset, the output `irq_n` is 1, and the control (address 0), current-level (address 1), current-channel (address 2), vector (address 3), enable (address 4) and pending (address 5) registers all read 0.
- R2: A request line sets its pending bit (bit n of address 5 for channel n) only while enable bit n (address 4) is 1. A request on a disabled channel leaves the pending register unchanged.
- R3: With the global enable set (control bit 0), a pending channel whose level outranks the current level drives `irq_n` low one clock after its pending bit is set.
- R4: `irq_n` stays 1 while the global enable is 0. It also stays 1 for a channel whose level (source register bits [3:0]) is 0 or not strictly greater than the current level.
- R5: Among pending, enabled channels the highest level wins, and on equal levels the lowest channel number wins. The vector register's bits [15:0] then show bits [31:16] of the winner's source register (source register n at address 32+n).
- R6: A read of the vector register while `irq_n` is 0 acknowledges the request. `irq_n` returns to 1 on the next clock, and the current-level and current-channel registers take the accepted channel's level and number.
- R7: While a channel is being served, a new request with a higher level asserts `irq_n` and can be acknowledged (nesting). Requests with an equal or lower level stay pending without asserting `irq_n`.
- R8: Writing the pending register with the current channel's bit set, while the context stack is not empty, restores the previous level and channel from the stack. The vector low half then shows the restored channel's fragment again, or 0 when the restored level is 0.
- R9: Vector register bits [31:16] are a read/write base. Bits [15:0] ignore writes.
- R10: The context stack holds STK_DEPTH entries. An acknowledge that finds it full stores nothing and sets the sticky overflow flag (control bit 1), which only reset clears.
- R11: Writing 1s to pending bits that do not include the current channel clears those bits and leaves the current level and channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | NUM_CH | Peripheral request lines, sampled each clock |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of the vector register acknowledges |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_n | output | 1 | Interrupt to the core, active low |

## Verification
The bench builds the block with 32 channels and 4-bit levels, and sets STK_DEPTH to 4. Because levels only go up to 15, at most fifteen nested acknowledges are possible, so the default 16-entry stack can never fill. With a 4-deep stack, five nested acknowledges reach the overflow path and its sticky flag. The same build also covers tie-breaking between two equal-level channels, the pop back to an idle level of 0, and nesting over an equal-level request.

// File: rtl/vnic_pkg.sv
package vnic_pkg;

    localparam int DATA_W = 32;
    localparam int VEC_W  = 16;

    localparam int CTRL_GIE_BIT = 0;
    localparam int CTRL_OVF_BIT = 1;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_CURLVL = 3'd1,
        SEL_CURCH  = 3'd2,
        SEL_VEC    = 3'd3,
        SEL_EN     = 3'd4,
        SEL_PEND   = 3'd5,
        SEL_SRC    = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic is_src,
                                            input logic low_page,
                                            input logic [2:0] lo3);
        if (is_src)
            return SEL_SRC;
        if (!low_page)
            return SEL_NONE;
        case (lo3)
            3'd0:    return SEL_CTRL;
            3'd1:    return SEL_CURLVL;
            3'd2:    return SEL_CURCH;
            3'd3:    return SEL_VEC;
            3'd4:    return SEL_EN;
            3'd5:    return SEL_PEND;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/vnic_arbiter.sv
module vnic_arbiter #(
    parameter int NUM_CH = 32,
    parameter int LVL_W  = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]       cand,
    input  logic [NUM_CH*LVL_W-1:0] levels,
    input  logic [LVL_W-1:0]        cur_lvl,
    output logic                    win_valid,
    output logic [CH_W-1:0]         win_ch,
    output logic [LVL_W-1:0]        win_lvl
);

    // Ascending scan with a strict compare: the first channel reaching the
    // top level keeps it, and level 0 can never win.
    always_comb begin
        win_lvl = '0;
        win_ch  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cand[i] && (levels[i*LVL_W +: LVL_W] > win_lvl)) begin
                win_lvl = levels[i*LVL_W +: LVL_W];
                win_ch  = CH_W'(i);
            end
        end
        win_valid = (win_lvl > cur_lvl);
    end

endmodule

// File: rtl/vnic_ctx_stack.sv
module vnic_ctx_stack #(
    parameter int DEPTH  = 16,
    parameter int ENT_W  = 9,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [ENT_W-1:0] din,
    output logic [ENT_W-1:0] dout,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             full;
    logic             empty;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (push) begin
            if (full)
                ovf_q <= 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[IDX_W'(cnt_q)] <= din;
    end

    assign dout = empty ? '0 : mem[IDX_W'(cnt_q - 1'b1)];
    assign cnt  = cnt_q;
    assign ovf  = ovf_q;

endmodule

// File: rtl/vnic.sv
module vnic
    import vnic_pkg::*;
#(
    parameter int NUM_CH    = 32,
    parameter int LVL_W     = 4,
    parameter int STK_DEPTH = 16,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] irq_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int CNT_W = $clog2(STK_DEPTH + 1);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [CH_W-1:0]  ch;
    } ctx_t;

    localparam int ENT_W = $bits(ctx_t);

    // ---------------- decode ----------------
    reg_sel_e        sel;
    logic [CH_W-1:0] src_idx;

    assign sel     = decode_sel(bus_addr[ADDR_W-1],
                                (bus_addr[ADDR_W-2:3] == '0),
                                bus_addr[2:0]);
    assign src_idx = bus_addr[CH_W-1:0];

    // ---------------- state ----------------
    logic              gie_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] pend_q;
    logic [LVL_W-1:0]  cur_lvl_q;
    logic [CH_W-1:0]   cur_ch_q;
    logic [VEC_W-1:0]  vec_base_q;
    logic [VEC_W-1:0]  vec_frag_q;
    logic [CH_W-1:0]   acc_ch_q;
    logic [LVL_W-1:0]  acc_lvl_q;
    logic              irq_n_q;

    logic [DATA_W-1:0]       src_q   [NUM_CH];
    logic [NUM_CH*LVL_W-1:0] lvl_flat;

    // ---------------- source registers ----------------
    for (genvar g = 0; g < NUM_CH; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                src_q[g] <= '0;
            else if (bus_wr && (sel == SEL_SRC) && (src_idx == CH_W'(g)))
                src_q[g] <= bus_wdata;
        end
        assign lvl_flat[g*LVL_W +: LVL_W] = src_q[g][LVL_W-1:0];
    end

    // ---------------- arbitration ----------------
    logic             win_valid;
    logic [CH_W-1:0]  win_ch;
    logic [LVL_W-1:0] win_lvl;

    vnic_arbiter #(
        .NUM_CH (NUM_CH),
        .LVL_W  (LVL_W)
    ) arb_i (
        .cand      (pend_q & en_q),
        .levels    (lvl_flat),
        .cur_lvl   (cur_lvl_q),
        .win_valid (win_valid),
        .win_ch    (win_ch),
        .win_lvl   (win_lvl)
    );

    // ---------------- acknowledge / end of service ----------------
    logic              ack;
    logic              pend_wr;
    logic              pop;
    logic [NUM_CH-1:0] clr_mask;
    logic [ENT_W-1:0]  stk_dout;
    logic [CNT_W-1:0]  stk_cnt;
    logic              stk_ovf;
    ctx_t              top_ctx;
    ctx_t              push_ctx;

    assign ack      = bus_rd && (sel == SEL_VEC) && !irq_n_q;
    assign pend_wr  = bus_wr && (sel == SEL_PEND);
    assign clr_mask = pend_wr ? bus_wdata[NUM_CH-1:0] : '0;
    assign pop      = pend_wr && clr_mask[cur_ch_q] && (stk_cnt != '0) && !ack;
    assign push_ctx = '{lvl: cur_lvl_q, ch: cur_ch_q};
    assign top_ctx  = ctx_t'(stk_dout);

    vnic_ctx_stack #(
        .DEPTH (STK_DEPTH),
        .ENT_W (ENT_W)
    ) stk_i (
        .clk  (clk),
        .rst  (rst),
        .push (ack),
        .pop  (pop),
        .din  (push_ctx),
        .dout (stk_dout),
        .cnt  (stk_cnt),
        .ovf  (stk_ovf)
    );

    // ---------------- control registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q      <= 1'b0;
            en_q       <= '0;
            pend_q     <= '0;
            vec_base_q <= '0;
        end else begin
            if (bus_wr && (sel == SEL_CTRL))
                gie_q <= bus_wdata[CTRL_GIE_BIT];
            if (bus_wr && (sel == SEL_EN))
                en_q <= bus_wdata[NUM_CH-1:0];
            if (bus_wr && (sel == SEL_VEC))
                vec_base_q <= bus_wdata[DATA_W-1:VEC_W];
            pend_q <= (pend_q & ~clr_mask) | (irq_req & en_q);
        end
    end

    // ---------------- service state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_lvl_q  <= '0;
            cur_ch_q   <= '0;
            vec_frag_q <= '0;
            acc_ch_q   <= '0;
            acc_lvl_q  <= '0;
            irq_n_q    <= 1'b1;
        end else if (ack) begin
            cur_lvl_q <= acc_lvl_q;
            cur_ch_q  <= acc_ch_q;
            irq_n_q   <= 1'b1;
        end else if (pop) begin
            cur_lvl_q  <= top_ctx.lvl;
            cur_ch_q   <= top_ctx.ch;
            vec_frag_q <= (top_ctx.lvl == '0) ? '0 : src_q[top_ctx.ch][DATA_W-1:VEC_W];
            irq_n_q    <= 1'b1;
        end else begin
            irq_n_q <= !(gie_q && win_valid);
            if (gie_q && win_valid) begin
                vec_frag_q <= src_q[win_ch][DATA_W-1:VEC_W];
                acc_ch_q   <= win_ch;
                acc_lvl_q  <= win_lvl;
            end
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                bus_rdata[CTRL_GIE_BIT] = gie_q;
                bus_rdata[CTRL_OVF_BIT] = stk_ovf;
            end
            SEL_CURLVL: bus_rdata = DATA_W'(cur_lvl_q);
            SEL_CURCH:  bus_rdata = DATA_W'(cur_ch_q);
            SEL_VEC:    bus_rdata = {vec_base_q, vec_frag_q};
            SEL_EN:     bus_rdata = DATA_W'(en_q);
            SEL_PEND:   bus_rdata = DATA_W'(pend_q);
            SEL_SRC:    bus_rdata = src_q[src_idx];
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_n = irq_n_q;

endmodule

// File: rtl/vnic_chk.sv
module vnic_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_n,
    input logic             gie,
    input logic             ack,
    input logic             pop,
    input logic [CNT_W-1:0] depth,
    input logic             ovf
);

    // R1
    reset_irq_high_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_n);

    // R4
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> $past(gie));

    // R6
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> irq_n);

    // R8
    pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
        pop |=> (depth == CNT_W'($past(depth) - 1'b1)));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        depth <= CNT_W'(DEPTH));

endmodule

bind vnic vnic_chk #(
    .DEPTH (STK_DEPTH),
    .CNT_W ($clog2(STK_DEPTH + 1))
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .irq_n (irq_n),
    .gie   (gie_q),
    .ack   (ack),
    .pop   (pop),
    .depth (stk_cnt),
    .ovf   (stk_ovf)
);

// File: tb/vnic_tb_top.sv
module vnic_tb_top;

    localparam int NCH = 32;
    localparam logic [5:0] A_CTRL = 6'd0, A_CURLVL = 6'd1, A_CURCH = 6'd2,
                           A_VEC = 6'd3, A_EN = 6'd4, A_PEND = 6'd5, A_SRC = 6'd32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  irq_req = '0;
    logic [5:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_n;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vnic #(
        .NUM_CH    (NCH),
        .LVL_W     (4),
        .STK_DEPTH (4),
        .ADDR_W    (6)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (irq_req),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    // Scoreboard: kind 0 compares read data, kind 1 compares the irq pin.
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always @(negedge clk) begin
        item_t it;
        logic [31:0] got;
        #2;
        while (sb_q.size() > 0) begin
            it  = sb_q.pop_front();
            got = (it.kind == 0) ? bus_rdata : {31'b0, irq_n};
            n_cmp++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    function automatic logic [31:0] srcw(int ch, int lvl);
        return {16'hA000 | 16'(ch), 12'h000, 4'(lvl)};
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_exp(logic [5:0] a, logic [31:0] e, string tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        sb_q.push_back('{0, e, tag});
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic pin_exp(logic e, string tag);
        sb_q.push_back('{1, {31'b0, e}, tag});
    endtask

    task automatic pulse_req(int ch);
        irq_req[ch] = 1'b1;
        cyc(2);
        irq_req[ch] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        pin_exp(1'b1, "R1 irq_n");
        rd_exp(A_CTRL,   32'h0, "R1 ctrl");
        rd_exp(A_EN,     32'h0, "R1 enable");
        rd_exp(A_PEND,   32'h0, "R1 pending");
        rd_exp(A_CURLVL, 32'h0, "R1 curlvl");
        rd_exp(A_CURCH,  32'h0, "R1 curch");
        rd_exp(A_VEC,    32'h0, "R1 vector");

        // R2 disabled channel ignores its request
        pulse_req(5);
        pin_exp(1'b1, "R2 irq_n");
        rd_exp(A_PEND, 32'h0, "R2 pending");

        // R9 base writable, fragment not
        wr(A_VEC, 32'h1234_FFFF);
        rd_exp(A_VEC, 32'h1234_0000, "R9 vector");

        wr(A_SRC + 6'd3, srcw(3, 5));
        rd_exp(A_SRC + 6'd3, srcw(3, 5), "R5 src readback");
        wr(A_EN, 32'hFFFF_FFFF);

        // R4 global enable off
        pulse_req(3);
        pin_exp(1'b1, "R4 gie off");
        rd_exp(A_PEND, 32'h8, "R2 pending set");

        // R3 assert after enabling
        wr(A_CTRL, 32'h1);
        cyc(1);
        pin_exp(1'b0, "R3 irq_n");
        rd_exp(A_VEC, 32'h1234_A003, "R5 vector ch3");
        pin_exp(1'b1, "R6 released");
        rd_exp(A_CURLVL, 32'd5, "R6 curlvl");
        rd_exp(A_CURCH,  32'd3, "R6 curch");

        // R7 equal and lower levels do not nest
        wr(A_SRC + 6'd7, srcw(7, 5));
        wr(A_SRC + 6'd9, srcw(9, 3));
        irq_req[7] = 1'b1;
        irq_req[9] = 1'b1;
        cyc(2);
        irq_req = '0;
        pin_exp(1'b1, "R7 no nest");
        rd_exp(A_PEND, 32'h0000_0288, "R7 pending");

        // R5 tie at level 9: channel 10 beats 12
        wr(A_SRC + 6'd10, srcw(10, 9));
        wr(A_SRC + 6'd12, srcw(12, 9));
        irq_req[10] = 1'b1;
        irq_req[12] = 1'b1;
        cyc(2);
        irq_req = '0;
        pin_exp(1'b0, "R7 nest");
        rd_exp(A_VEC, 32'h1234_A00A, "R5 tie vector");
        pin_exp(1'b1, "R6 released nested");
        rd_exp(A_CURLVL, 32'd9,  "R6 curlvl nested");
        rd_exp(A_CURCH,  32'd10, "R6 curch nested");

        // R8 end of service pops back to channel 3
        wr(A_PEND, 32'h1 << 10);
        rd_exp(A_VEC, 32'h1234_A003, "R8 vector restored");
        pin_exp(1'b0, "R7 ch12 accepted");
        rd_exp(A_CURLVL, 32'd5, "R8 curlvl");
        rd_exp(A_CURCH,  32'd3, "R8 curch");
        rd_exp(A_VEC, 32'h1234_A00C, "R7 vector ch12");
        rd_exp(A_CURLVL, 32'd9, "R6 curlvl ch12");
        wr(A_PEND, 32'h1 << 12);
        rd_exp(A_CURLVL, 32'd5, "R8 curlvl after ch12");

        // R11 clearing a non-current bit does not pop
        wr(A_PEND, 32'h1 << 9);
        rd_exp(A_CURLVL, 32'd5, "R11 curlvl");
        rd_exp(A_CURCH,  32'd3, "R11 curch");
        rd_exp(A_PEND, 32'h0000_0088, "R11 pending");

        // R8 pop to idle level 0
        wr(A_PEND, 32'h1 << 3);
        rd_exp(A_VEC, 32'h1234_0000, "R8 vector idle");
        rd_exp(A_CURLVL, 32'd0, "R8 curlvl idle");
        pin_exp(1'b0, "R3 ch7 accepted");
        wr(A_PEND, 32'h1 << 7);
        cyc(1);
        pin_exp(1'b1, "R11 irq withdrawn");
        rd_exp(A_PEND, 32'h0, "R11 pending empty");

        // R4 level 0 never interrupts
        wr(A_SRC + 6'd20, srcw(20, 0));
        pulse_req(20);
        pin_exp(1'b1, "R4 level0");
        rd_exp(A_PEND, 32'h1 << 20, "R4 pending level0");
        wr(A_PEND, 32'h1 << 20);

        // R10 overflow with a 4-deep stack
        for (int k = 1; k <= 5; k++) begin
            wr(A_SRC + 6'(20 + k), srcw(20 + k, k));
            pulse_req(20 + k);
            pin_exp(1'b0, "R10 nest asserted");
            rd_exp(A_VEC, 32'h1234_A000 | (20 + k), "R10 vector");
            if (k == 4)
                rd_exp(A_CTRL, 32'h1, "R10 no overflow yet");
        end
        rd_exp(A_CTRL,   32'h3, "R10 overflow flag");
        rd_exp(A_CURLVL, 32'd5, "R10 curlvl");
        rd_exp(A_CURCH,  32'd25, "R10 curch");
        cyc(2);
        rd_exp(A_CTRL, 32'h3, "R10 flag sticky");

        cyc(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule